// File: doc/BRIEF.md
# Page Translation Buffer with Two-Level Table Walker

This block turns 32-bit linear addresses into physical addresses for a 4 KB page size. It keeps the most recent page-to-frame mappings in a small, fully associative buffer. A request whose page is held there is answered on the next clock. A request that misses is handed to a walker. The walker reads two 32-bit entries from memory, one after the other, through a read port that allows a single outstanding read. The first read is a directory entry, located from a base register. The second is a table entry, located from the directory entry. If the mapping is valid, the walker stores it in the buffer and returns the translated address. If either entry is marked absent, the walker returns a page-fault response instead.

The address splits into three fields. Bits 31:22 index the directory, bits 21:12 index the table, and bits 11:0 are the byte offset, which passes through unchanged. Every memory entry uses bit 0 as its present flag and bits 31:12 as a frame number: the next table's frame for a directory entry, the data frame for a table entry. A flush input clears the buffer. The block stalls new requests while a walk is in progress.

Top module: `tlb_walker`

## Requirements
- R1: The first walk read goes to `dir_base + 4 * vaddr[31:22]`.
- R2: When the directory entry has bit 0 set, the second walk read goes to `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`.
- R3: A successful translation returns `{pte[31:12], vaddr[11:0]}`, where `pte` is the table entry, with `rsp_fault` low.
- R4: A request whose page is held in the buffer gets `rsp_valid` in the cycle after it is accepted, and no memory read is issued.
- R5: A completed walk stores its mapping, so a later request anywhere in the same page is a buffer hit.
- R6: An entry with bit 0 clear, at either level, ends the walk with `rsp_fault` high and `rsp_paddr` zero. A directory entry with bit 0 clear causes no second read.
- R7: A faulting translation is not stored: repeating the request starts a new walk.
- R8: The buffer holds 8 mappings and replaces them in round-robin order. The replacement pointer starts at slot 0 after reset or flush, so the ninth distinct fill evicts the first.
- R9: A one-cycle pulse on `flush` invalidates every stored mapping.
- R10: At most one memory read is outstanding. `mem_req` is a one-cycle pulse, and `req_ready` stays low from the acceptance of a missing request until its response.
- R11: While and after reset, `req_ready` is high, and `rsp_valid` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 32 | Linear address to translate |
| req_ready | output | 1 | Block can accept a request (no walk in progress) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address (zero on fault) |
| rsp_fault | output | 1 | Response is a page fault |
| dir_base | input | 32 | Physical base address of the directory |
| flush | input | 1 | Invalidate all stored mappings |
| mem_req | output | 1 | Walk read request pulse |
| mem_addr | output | 32 | Walk read address |
| mem_rvalid | input | 1 | Walk read data valid |
| mem_rdata | input | 32 | Walk read data (entry) |

## Verification
Eviction order is the hardest case to reach from the ports. Nothing outside the block shows which slot the replacement pointer holds, so a specific victim can only be predicted from a known starting point. The bench first pulses flush, which also returns the pointer to slot 0. It then fills eight distinct pages and adds a ninth. It tells hit from miss by response latency and by counting memory reads, and expects the second page to hit while the first page walks again. Faults at the second level are reached through a memory model whose table entries are absent for one particular table index.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
  typedef enum logic [2:0] {
    WK_IDLE,
    WK_RD_DIR,
    WK_WT_DIR,
    WK_RD_PT,
    WK_WT_PT,
    WK_FILL,
    WK_FAULT
  } walk_state_t;
endpackage

// File: rtl/tlbw_buf.sv
module tlbw_buf #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PFN_W-1:0] lk_pfn,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PFN_W-1:0] wr_pfn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] slot_vld;
  logic [VPN_W-1:0]   slot_vpn [ENTRIES];
  logic [PFN_W-1:0]   slot_pfn [ENTRIES];
  logic [PTR_W-1:0]   rr_ptr;
  logic [ENTRIES-1:0] match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match[g] = slot_vld[g] && (slot_vpn[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) lk_pfn = lk_pfn | slot_pfn[i];
  end

  assign lk_hit = (|match) && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      slot_vld <= '0;
      rr_ptr   <= '0;
    end else if (wr_en) begin
      slot_vld[rr_ptr] <= 1'b1;
      rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !flush) begin
      slot_vpn[rr_ptr] <= wr_vpn;
      slot_pfn[rr_ptr] <= wr_pfn;
    end
  end
endmodule

// File: rtl/tlbw_walk.sv
module tlbw_walk
  import tlbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        start_vaddr,
  input  logic [ADDR_W-1:0]        dir_base,
  input  logic                     mem_rvalid,
  input  logic [ADDR_W-1:0]        mem_rdata,
  output logic                     idle,
  output logic                     mem_req,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     fill_en,
  output logic                     fault_en,
  output logic [ADDR_W-1:0]        walk_vaddr,
  output logic [ADDR_W-OFF_W-1:0]  walk_pfn
);
  localparam int PFN_W = ADDR_W - OFF_W;
  localparam int PAD_W = ADDR_W - IDX_W - 2;

  walk_state_t      state;
  logic [ADDR_W-1:0] vaddr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PFN_W-1:0]  pfn_q;

  function automatic logic [ADDR_W-1:0] scaled(input logic [IDX_W-1:0] idx);
    return {{PAD_W{1'b0}}, idx, 2'b00};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WK_IDLE;
      vaddr_q <= '0;
      addr_q  <= '0;
      pfn_q   <= '0;
    end else begin
      case (state)
        WK_IDLE: if (start) begin
          vaddr_q <= start_vaddr;
          addr_q  <= dir_base + scaled(start_vaddr[ADDR_W-1 -: IDX_W]);
          state   <= WK_RD_DIR;
        end
        WK_RD_DIR: state <= WK_WT_DIR;
        WK_WT_DIR: if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            addr_q <= {mem_rdata[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                      + scaled(vaddr_q[OFF_W +: IDX_W]);
            state  <= WK_RD_PT;
          end else begin
            state  <= WK_FAULT;
          end
        end
        WK_RD_PT: state <= WK_WT_PT;
        WK_WT_PT: if (mem_rvalid) begin
          if (mem_rdata[0]) begin
            pfn_q <= mem_rdata[ADDR_W-1:OFF_W];
            state <= WK_FILL;
          end else begin
            state <= WK_FAULT;
          end
        end
        default: state <= WK_IDLE;
      endcase
    end
  end

  assign idle       = (state == WK_IDLE);
  assign mem_req    = (state == WK_RD_DIR) || (state == WK_RD_PT);
  assign mem_addr   = addr_q;
  assign fill_en    = (state == WK_FILL);
  assign fault_en   = (state == WK_FAULT);
  assign walk_vaddr = vaddr_q;
  assign walk_pfn   = pfn_q;
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 32,
  parameter int OFF_W   = 12,
  parameter int IDX_W   = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              flush,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata
);
  localparam int VPN_W = ADDR_W - OFF_W;

  logic              lk_hit;
  logic [VPN_W-1:0]  lk_pfn;
  logic              accept;
  logic              walk_idle;
  logic              fill_en;
  logic              fault_en;
  logic [ADDR_W-1:0] walk_vaddr;
  logic [VPN_W-1:0]  walk_pfn;

  assign req_ready = walk_idle;
  assign accept    = req_valid && walk_idle;

  tlbw_buf #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(VPN_W)) u_buf (
    .clk    (clk),
    .rst    (rst),
    .flush  (flush),
    .lk_vpn (req_vaddr[ADDR_W-1:OFF_W]),
    .lk_hit (lk_hit),
    .lk_pfn (lk_pfn),
    .wr_en  (fill_en),
    .wr_vpn (walk_vaddr[ADDR_W-1:OFF_W]),
    .wr_pfn (walk_pfn)
  );

  tlbw_walk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .start       (accept && !lk_hit),
    .start_vaddr (req_vaddr),
    .dir_base    (dir_base),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .idle        (walk_idle),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .fill_en     (fill_en),
    .fault_en    (fault_en),
    .walk_vaddr  (walk_vaddr),
    .walk_pfn    (walk_pfn)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      if (accept && lk_hit) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= {lk_pfn, req_vaddr[OFF_W-1:0]};
      end else if (fill_en) begin
        rsp_valid <= 1'b1;
        rsp_paddr <= {walk_pfn, walk_vaddr[OFF_W-1:0]};
      end else if (fault_en) begin
        rsp_valid <= 1'b1;
        rsp_fault <= 1'b1;
        rsp_paddr <= '0;
      end
    end
  end
endmodule

// File: rtl/tlbw_chk.sv
module tlbw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic              mem_req,
  input logic              mem_rvalid,
  input logic              lk_hit
);
  logic rd_open;

  always_ff @(posedge clk) begin
    if (rst)             rd_open <= 1'b0;
    else if (mem_req)    rd_open <= 1'b1;
    else if (mem_rvalid) rd_open <= 1'b0;
  end

  // R4
  hit_next_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && lk_hit |=> rsp_valid && !rsp_fault);

  // R10
  miss_stall_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && !lk_hit |=> !req_ready && !rsp_valid);

  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !rd_open && !req_ready);

  // R10
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_paddr == '0);

  // R11
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid && !mem_req && req_ready);
endmodule

bind tlb_walker tlbw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .rsp_fault  (rsp_fault),
  .rsp_paddr  (rsp_paddr),
  .mem_req    (mem_req),
  .mem_rvalid (mem_rvalid),
  .lk_hit     (lk_hit)
);

// File: tb/tlb_walker_tb.sv
module tlb_walker_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DIR_BASE = 32'h0010_0000;
  localparam logic [31:0] PT_AREA  = 32'h0020_0000;

  // vector: [33:2] vaddr, [1] expect fault, [0] expect hit
  localparam logic [33:0] VEC [8] = '{
    {32'h0040_1234, 1'b0, 1'b0},
    {32'h0040_1ABC, 1'b0, 1'b1},
    {32'h0140_3008, 1'b1, 1'b0},
    {32'h0140_3008, 1'b1, 1'b0},
    {32'h0080_7FFF, 1'b1, 1'b0},
    {32'h0080_8010, 1'b0, 1'b0},
    {32'h0040_1000, 1'b0, 1'b1},
    {32'h0080_8FFC, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        flush = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0;
  int errors = 0;
  int rd_count = 0;
  logic [31:0] rd_addr0, rd_addr1;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_walker u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .dir_base(DIR_BASE), .flush(flush),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata)
  );

  // Memory model: directory index 5 absent, table index 7 absent everywhere
  function automatic logic [19:0] frame_of(input int d, input int t);
    return 20'h80000 ^ {d[9:0], t[9:0]};
  endfunction

  function automatic logic [31:0] mem_read(input logic [31:0] a);
    int d, t;
    if (a >= DIR_BASE && a < DIR_BASE + 32'h1000) begin
      d = int'((a - DIR_BASE) >> 2);
      if (d == 5) return 32'h0;
      return {20'h00200 + 20'(d), 11'b0, 1'b1};
    end
    if (a >= PT_AREA && a < PT_AREA + 32'h0040_0000) begin
      d = int'((a - PT_AREA) >> 12);
      t = int'(a[11:2]);
      if (t == 7) return 32'h0;
      return {frame_of(d, t), 11'b0, 1'b1};
    end
    return 32'hDEAD_BEE0;
  endfunction

  initial begin
    logic        pend = 1'b0;
    logic [31:0] pend_a = '0;
    forever begin
      @(negedge clk);
      mem_rvalid = 1'b0;
      if (pend) begin
        mem_rdata  = mem_read(pend_a);
        mem_rvalid = 1'b1;
        pend = 1'b0;
      end
      if (mem_req) begin
        if (rd_count == 0) rd_addr0 = mem_addr;
        else               rd_addr1 = mem_addr;
        rd_count++;
        pend   = 1'b1;
        pend_a = mem_addr;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xlate(input logic [31:0] va, output logic [31:0] pa,
                       output logic flt, output int lat, output logic rdy1);
    @(negedge clk);
    rd_count  = 0;
    req_valid = 1'b1;
    req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rdy1 = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    pa  = rsp_paddr;
    flt = rsp_fault;
  endtask

  task automatic pulse_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  function automatic logic [31:0] rr_page(input int i);
    return {10'd3, 10'(16 + i), 12'h044};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa;
    logic flt, rdy1;
    int lat, d, t;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(req_ready == 1'b1, "R11 ready in reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R11 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    chk(mem_req == 1'b0, "R11 mem_req in reset", 32'(mem_req), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R11 idle after reset",
        {req_ready, rsp_valid}, 32'h2);

    foreach (VEC[i]) begin
      logic [31:0] va;
      logic ef, eh;
      va = VEC[i][33:2];
      ef = VEC[i][1];
      eh = VEC[i][0];
      d  = int'(va[31:22]);
      t  = int'(va[21:12]);
      xlate(va, pa, flt, lat, rdy1);
      chk(flt == ef, "R6 fault flag", 32'(flt), 32'(ef));
      if (ef) chk(pa == 32'h0, "R6 fault paddr", pa, 32'h0);
      else    chk(pa == {frame_of(d, t), va[11:0]}, "R3 paddr", pa,
                  {frame_of(d, t), va[11:0]});
      if (eh) begin
        chk(lat == 1, "R4 hit latency", lat, 1);
        chk(rd_count == 0, "R4/R5 hit reads", rd_count, 0);
      end else begin
        chk(lat > 1, "R5/R7 miss walks", lat, 2);
        chk(rdy1 == 1'b0, "R10 stall during walk", 32'(rdy1), 32'h0);
        chk(rd_addr0 == DIR_BASE + 32'(4 * d), "R1 directory address",
            rd_addr0, DIR_BASE + 32'(4 * d));
        if (d == 5) chk(rd_count == 1, "R6 no table read", rd_count, 1);
        else begin
          chk(rd_count == 2, "R2 read count", rd_count, 2);
          chk(rd_addr1 == PT_AREA + 32'(d * 4096 + 4 * t), "R2 table address",
              rd_addr1, PT_AREA + 32'(d * 4096 + 4 * t));
        end
      end
    end

    // R9 flush invalidates
    pulse_flush();
    xlate(32'h0040_1234, pa, flt, lat, rdy1);
    chk(rd_count == 2, "R9 walk after flush", rd_count, 2);
    chk(pa == {frame_of(1, 1), 12'h234}, "R9 paddr after flush", pa,
        {frame_of(1, 1), 12'h234});
    pulse_flush();
    xlate(32'h0080_8010, pa, flt, lat, rdy1);
    chk(rd_count == 2, "R9 second page flushed", rd_count, 2);

    // R8 round robin from slot 0
    pulse_flush();
    for (int i = 0; i < 9; i++) xlate(rr_page(i), pa, flt, lat, rdy1);
    chk(rd_count == 2, "R8 ninth fill walks", rd_count, 2);
    xlate(rr_page(1), pa, flt, lat, rdy1);
    chk(lat == 1 && rd_count == 0, "R8 second page kept", lat, 1);
    chk(pa == {frame_of(3, 17), 12'h044}, "R8 kept paddr", pa,
        {frame_of(3, 17), 12'h044});
    xlate(rr_page(0), pa, flt, lat, rdy1);
    chk(rd_count == 2, "R8 first page evicted", rd_count, 2);
    xlate(rr_page(2), pa, flt, lat, rdy1);
    chk(lat == 1, "R8 third page kept", lat, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule